// File: doc/BRIEF.md
# Mass-Read Signature and Compare Unit

This unit sweeps the main array of an embedded non-volatile memory on command. A single start pulse captures a reference word and a last word address. The unit then asks for every word from address 0 up to that last address, one request at a time, through a read port whose answer may arrive after any number of cycles. Each word that comes back is folded into a 32-bit multiple-input signature register, which is seeded with all ones.

The same word is also compared with the captured reference. Any difference sets a fail bit that stays set for the rest of the sweep. When the word at the last address has been folded, the unit pulses done for one cycle. At that point the final signature is on the signature output, and the match flag reports whether every word equalled the reference. Both results hold until the next sweep is started.

Software uses the signature to confirm that the array holds a known image. It uses the match flag to confirm that an erase or fill left one uniform value everywhere.

Top module: `msig_sweep`

## Requirements
- R1: While reset is held and directly after it, sigOut reads 0xFFFFFFFF, and matchFlag, donePulse and rdReq read 0.
- R2: A startPulse seen while the unit is idle reloads sigOut with 0xFFFFFFFF and clears matchFlag by the next cycle. rdReq rises in the cycle after the start is sampled.
- R3: rdReq is high for exactly one cycle per word, and only one request is outstanding at a time. The next request follows the cycle after the rdValid that answers the previous one. rdAddr runs 0, 1, 2, … up to the captured last address.
- R4: Each rdValid that answers an outstanding request changes the signature S to ((S << 1) XOR (S[31] ? 0x04C11DB7 : 0)) XOR rdData.
- R5: An rdValid that arrives while no request is outstanding changes neither the signature nor the result.
- R6: donePulse is high for exactly one cycle: the cycle after the rdValid for the last address. From that cycle on, sigOut shows the final signature and holds it until the next accepted start.
- R7: matchFlag is 1 from the done cycle only if every word of the sweep equalled the reference. One differing word, even the first, makes it 0. It holds until the next accepted start.
- R8: refWord and lastAddr are sampled only when a start is accepted. Changing them during a sweep has no effect.
- R9: A startPulse that arrives while a sweep is running is ignored. The sweep carries on to its normal end.
- R10: A startPulse in the same cycle as donePulse is accepted. A new sweep begins, with rdReq and rdAddr 0 in the following cycle.
- R11: With lastAddr 0, the sweep reads exactly one word at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| startPulse | input | 1 | Begin a sweep (taken only when idle) |
| refWord | input | 32 | Reference word for the all-equal check |
| lastAddr | input | 16 | Last word address of the sweep |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | 16 | Word address of the request |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data |
| sigOut | output | 32 | Signature register |
| matchFlag | output | 1 | All words equalled the reference |
| donePulse | output | 1 | One-cycle end-of-sweep indication |

## Verification
Two events can fall in the same cycle: the done pulse that ends one sweep and a start pulse that opens the next. The bench drives startPulse during the exact cycle in which it sees donePulse. It then checks three things: that cycle still shows the finished signature and match result; the next cycle shows a reseeded signature, a cleared flag and a request for address 0; and the chained sweep then completes with its own expected signature. Stray valids during the request cycle and after done, and starts and input changes in the middle of a sweep, are mixed with randomly sized sweeps under random read latency.

// File: rtl/msig_pkg.sv
package msig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } msigState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // accept start: seed signature, capture inputs
    logic fold;    // answered word present: fold and compare
    logic finish;  // fold of the last word: publish match
  } msigCtl_t;
endpackage

// File: rtl/msig_ctrl.sv
module msig_ctrl
  import msig_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     rdValid,
  input  logic     atLast,
  output msigCtl_t ctl,
  output logic     rdReq,
  output logic     donePulse
);
  msigState_t stateQ;
  logic       doneQ;

  always_comb begin
    ctl        = '0;
    ctl.load   = (stateQ == ST_IDLE) && startPulse;
    ctl.fold   = (stateQ == ST_WAIT) && rdValid;
    ctl.finish = ctl.fold && atLast;
    rdReq      = (stateQ == ST_REQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= ctl.finish;
      unique case (stateQ)
        ST_IDLE: if (ctl.load) stateQ <= ST_REQ;
        ST_REQ:  stateQ <= ST_WAIT;
        ST_WAIT: if (ctl.finish) stateQ <= ST_IDLE;
                 else if (ctl.fold) stateQ <= ST_REQ;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign donePulse = doneQ;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !rdReq); // R6
endmodule

// File: rtl/msig_dp.sv
module msig_dp
  import msig_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 16,
  parameter logic [31:0] POLY   = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  msigCtl_t          ctl,
  input  logic [DATA_W-1:0] refWord,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              atLast,
  output logic [DATA_W-1:0] sigOut,
  output logic              matchFlag
);
  localparam logic [DATA_W-1:0] SEED = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] TAPS = DATA_W'(POLY);

  logic [DATA_W-1:0] sigQ, refQ, sigNext;
  logic [ADDR_W-1:0] addrQ, lastQ;
  logic              failQ, matchQ, mism;

  always_comb begin
    sigNext = {sigQ[DATA_W-2:0], 1'b0} ^ (sigQ[DATA_W-1] ? TAPS : '0) ^ rdData;
    mism    = (rdData != refQ);
    atLast  = (addrQ == lastQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigQ   <= SEED;
      refQ   <= '0;
      addrQ  <= '0;
      lastQ  <= '0;
      failQ  <= 1'b0;
      matchQ <= 1'b0;
    end else if (ctl.load) begin
      sigQ   <= SEED;
      refQ   <= refWord;
      lastQ  <= lastAddr;
      addrQ  <= '0;
      failQ  <= 1'b0;
      matchQ <= 1'b0;
    end else if (ctl.fold) begin
      sigQ  <= sigNext;
      failQ <= failQ | mism;
      if (!atLast) addrQ <= addrQ + 1'b1;
      if (ctl.finish) matchQ <= !(failQ | mism);
    end
  end

  assign rdAddr    = addrQ;
  assign sigOut    = sigQ;
  assign matchFlag = matchQ;

  AST_SEED_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (sigQ == SEED) && !matchQ); // R2
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    addrQ <= lastQ); // R3
  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(refQ) && $stable(lastQ)); // R8
  AST_SIG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load && !ctl.fold |=> $stable(sigQ)); // R5
endmodule

// File: rtl/msig_sweep.sv
module msig_sweep
  import msig_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 16,
  parameter logic [31:0] POLY   = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [DATA_W-1:0] refWord,
  input  logic [ADDR_W-1:0] lastAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] sigOut,
  output logic              matchFlag,
  output logic              donePulse
);
  msigCtl_t ctl;
  logic     atLast;

  msig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .rdValid(rdValid),
    .atLast(atLast), .ctl(ctl), .rdReq(rdReq), .donePulse(donePulse)
  );

  msig_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .POLY(POLY)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .refWord(refWord), .lastAddr(lastAddr),
    .rdData(rdData), .rdAddr(rdAddr), .atLast(atLast), .sigOut(sigOut),
    .matchFlag(matchFlag)
  );

  AST_MATCH_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> donePulse); // R7
endmodule

// File: tb/msig_sweep_tb_top.sv
module msig_sweep_tb_top;
  logic        clk = 1'b0;
  logic        rstN, startPulse, rdValid;
  logic [31:0] refWord, rdData;
  logic [15:0] lastAddr;
  logic        rdReq, matchFlag, donePulse;
  logic [15:0] rdAddr;
  logic [31:0] sigOut;

  int  checks = 0;
  int  fails  = 0;
  bit  ended  = 0;
  logic [31:0] mem [64];

  always #5 clk = ~clk;

  msig_sweep dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .refWord(refWord),
    .lastAddr(lastAddr), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .sigOut(sigOut), .matchFlag(matchFlag), .donePulse(donePulse)
  );

  function automatic logic [31:0] misr(input logic [31:0] s, input logic [31:0] d);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h04C11DB7 : 32'h0) ^ d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // opts: 1 change inputs mid-sweep, 2 start mid-sweep, 4 chain start at done,
  //       8 already started (skip start), 16 stray valid in request cycle
  task automatic sweep(input int last, input logic [31:0] refw, input int opts);
    logic [31:0] es = 32'hFFFF_FFFF;
    logic        em = 1'b1;
    for (int i = 0; i <= last; i++) begin
      es = misr(es, mem[i]);
      if (mem[i] != refw) em = 1'b0;
    end
    if ((opts & 8) == 0) begin
      @(negedge clk);
      refWord = refw; lastAddr = 16'(last); startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    chk("R2 seed", sigOut, 32'hFFFF_FFFF);
    chk("R2 match cleared", {31'b0, matchFlag}, 32'd0);
    if ((opts & 1) != 0) begin
      refWord = ~refw; lastAddr = 16'(last + 5); // R8
    end
    for (int i = 0; i <= last; i++) begin
      int w = 0;
      int d;
      while (!rdReq && w < 20) begin @(negedge clk); w++; end
      chk("R3 request", {31'b0, rdReq}, 32'd1);
      chk("R3 address", {16'b0, rdAddr}, 32'(i));
      if ((opts & 2) != 0 && i == 1) startPulse = 1'b1;          // R9
      if ((opts & 16) != 0 && i == 0) begin rdValid = 1'b1; rdData = ~mem[0]; end // R5
      d = $urandom_range(1, 3);
      repeat (d) begin
        @(negedge clk);
        startPulse = 1'b0; rdValid = 1'b0;
        chk("R3 single request", {31'b0, rdReq}, 32'd0);
      end
      rdValid = 1'b1; rdData = mem[i];
      @(negedge clk);
      rdValid = 1'b0; rdData = $urandom;
    end
    chk("R6 done", {31'b0, donePulse}, 32'd1);
    chk("R4 signature", sigOut, es);
    chk("R7 match", {31'b0, matchFlag}, {31'b0, em});
    refWord = refw; lastAddr = 16'(last);
    if ((opts & 4) != 0) begin
      startPulse = 1'b1; // R10: start in the done cycle
      @(negedge clk);
      startPulse = 1'b0;
      chk("R10 request", {31'b0, rdReq}, 32'd1);
      chk("R10 address", {16'b0, rdAddr}, 32'd0);
    end else begin
      @(negedge clk);
      chk("R6 single done", {31'b0, donePulse}, 32'd0);
      chk("R6 held", sigOut, es);
      rdValid = 1'b1; rdData = $urandom;  // R5 stray after done
      @(negedge clk);
      rdValid = 1'b0;
      @(negedge clk);
      chk("R5 stray ignored", sigOut, es);
      chk("R7 held", {31'b0, matchFlag}, {31'b0, em});
    end
  endtask

  task automatic fill(input logic [31:0] v, input int bad);
    for (int i = 0; i < 64; i++) mem[i] = v;
    if (bad >= 0) mem[bad] = v ^ 32'h0000_0100;
  endtask

  initial begin
    void'($urandom(32'd2718));
    rstN = 1'b0; startPulse = 1'b0; rdValid = 1'b0;
    refWord = '0; rdData = '0; lastAddr = '0;
    repeat (3) @(negedge clk);
    chk("R1 sig in reset", sigOut, 32'hFFFF_FFFF);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sig", sigOut, 32'hFFFF_FFFF);
    chk("R1 match", {31'b0, matchFlag}, 32'd0);
    chk("R1 done", {31'b0, donePulse}, 32'd0);
    chk("R1 req", {31'b0, rdReq}, 32'd0);

    fill(32'h5A5A_0F0F, -1);  sweep(15, 32'h5A5A_0F0F, 0);   // R7 all equal
    fill(32'h1234_5678, 0);   sweep(20, 32'h1234_5678, 0);   // R7 first word differs
    fill(32'hFFFF_FFFF, 9);   sweep(12, 32'hFFFF_FFFF, 16);  // R5 stray in request cycle
    fill(32'hCAFE_0001, -1);  sweep(0, 32'hCAFE_0001, 0);    // R11 single word
    fill(32'h0BAD_F00D, -1);  sweep(10, 32'h0BAD_F00D, 1);   // R8 inputs changed mid-sweep
    fill(32'h7777_0000, -1);  sweep(8, 32'h7777_0000, 2);    // R9 start mid-sweep
    fill(32'hA5A5_A5A5, -1);  sweep(6, 32'hA5A5_A5A5, 4);    // R10 chain
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    sweep(6, 32'hA5A5_A5A5, 8);                               // R10 chained sweep
    for (int k = 0; k < 8; k++) begin
      int last = $urandom_range(0, 63);
      logic [31:0] v = $urandom;
      if (k % 2 == 0) fill(v, -1);
      else fill(v, $urandom_range(0, last));
      if (k == 5) for (int i = 0; i < 64; i++) mem[i] = $urandom;
      sweep(last, v, 0);
    end
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule